// File: doc/BRIEF.md
# Colour Lookup Table Register Port

This block holds a 256-entry red/green/blue colour table and four overlay colours, and gives a processor access to them through a small bank of 32-bit word registers. Software first loads a shared index and then moves colours through one data register as three single-byte accesses in a row: red, then green, then blue. After every blue access the index steps on by one, so a whole table can be streamed without reloading it. A second data offset sends the same three-step sequence to the overlay colours. The overlay slot is chosen by the two low bits of the index.

A separate pixel port turns an 8-bit pixel value into a 24-bit colour one clock after it is presented. This port runs every cycle and does not depend on register traffic. Two of the overlay colours are driven out all the time for a hardware cursor.

Top module: `clut_dac_port`

## Requirements
- R1: A write to byte offset 0 loads the shared index from write data bits 31:24 and returns the component phase to red.
- R2: A write to offset 4 stores one component of palette entry [index]. A write to offset 12 stores one component of overlay entry (index mod 4). The component value is taken from write data bits 31:24.
- R3: Component accesses go red, green, blue in turn. The access that handles blue returns the phase to red and advances the index by one modulo 256, so index 255 wraps to 0.
- R4: A read at any offset returns the current component of palette entry [index] in read data bits 31:24, with bits 23:0 zero. It is visible on `reg_rdata` from the clock edge that takes the read, and it advances the same phase and index counters that writes use. If a read and a write are asserted together, only the write is performed.
- R5: After reset, every entry is black, except palette entry 255 and overlay entries 0 and 2, which are white (0xFFFFFF). The index is 0 and the phase is red.
- R6: A write to any offset other than 0, 4 and 12 changes no colour, no index and no phase.
- R7: `cur_mask_rgb` always shows overlay entry 2 and `cur_bit_rgb` always shows overlay entry 3. Each reflects a write from the edge that performs it.
- R8: `pix_rgb` holds {red[23:16], green[15:8], blue[7:0]} of palette entry `pix_index` as sampled at the previous clock edge. The lookup has a latency of one clock.
- R9: When a register write and a lookup of the same entry happen in the same cycle, `pix_rgb` returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset within the register bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, held between reads |
| pix_index | input | 8 | Pixel value to look up |
| pix_rgb | output | 24 | Looked-up colour, one clock later |
| cur_mask_rgb | output | 24 | Cursor colour for mask-only pixels (overlay 2) |
| cur_bit_rgb | output | 24 | Cursor colour for mask-and-bit pixels (overlay 3) |

## Verification
If the phase counter slips, the bytes land in the wrong colour channel. This shows on `pix_rgb` the first time that entry is looked up, and on `reg_rdata` at the next read. A wrong index step, missed or doubled, moves every later stream by one entry, so the first read-back after a blue access shows it. Faults in the overlay alias or in the decode of the ignored offsets show on the cursor outputs in the cycle after the write.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int COMP_W = 8;
  localparam int RGB_W  = 3 * COMP_W;
  localparam int N_OVL  = 4;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  function automatic phase_e phase_next(input phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  // Bit position of a component inside a packed {R,G,B} word.
  function automatic int unsigned comp_lsb(input phase_e p);
    case (p)
      PH_RED:  return 2 * COMP_W;
      PH_GRN:  return COMP_W;
      default: return 0;
    endcase
  endfunction

  // Colour an entry holds after reset.
  function automatic logic [RGB_W-1:0] reset_colour(input int unsigned ent,
                                                    input int unsigned n_pal);
    if (ent == n_pal - 1 || ent == n_pal || ent == n_pal + 2)
      return {RGB_W{1'b1}};
    return '0;
  endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int ENT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [IDX_W-1:0]  idx,
  output phase_e            phase,
  output logic              wr_comp,
  output logic              rd_comp,
  output logic [ENT_W-1:0]  wr_ent,
  output logic [COMP_W-1:0] wr_byte
);
  localparam logic [3:0] OFS_INDEX = 4'd0;
  localparam logic [3:0] OFS_PAL   = 4'd4;
  localparam logic [3:0] OFS_OVL   = 4'd12;
  localparam int unsigned N_PAL    = 1 << IDX_W;

  logic idx_load, hit_pal, hit_ovl, step, ctrl_wr;

  assign idx_load = reg_wr && (reg_addr == OFS_INDEX);
  assign hit_pal  = reg_wr && (reg_addr == OFS_PAL);
  assign hit_ovl  = reg_wr && (reg_addr == OFS_OVL);
  assign ctrl_wr  = reg_wr && !idx_load && !hit_pal && !hit_ovl;
  assign wr_comp  = hit_pal || hit_ovl;
  assign rd_comp  = reg_rd && !reg_wr;
  assign step     = wr_comp || rd_comp;
  assign wr_byte  = reg_wdata[DATA_W-1 -: COMP_W];

  always_comb begin
    if (hit_ovl)
      wr_ent = ENT_W'(N_PAL) + ENT_W'(idx[1:0]);
    else
      wr_ent = ENT_W'(idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (idx_load) begin
      idx   <= reg_wdata[DATA_W-1 -: IDX_W];
      phase <= PH_RED;
    end else if (step) begin
      phase <= phase_next(phase);
      if (phase == PH_BLU) idx <= idx + 1'b1;
    end
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R3
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (idx == $past(reg_wdata[DATA_W-1 -: IDX_W])) && (phase == PH_RED)); // R1
  AST_STEP_AFTER_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_BLU) |=> (idx == IDX_W'($past(idx) + 1'b1)) && (phase == PH_RED)); // R3
  AST_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> $stable(idx) && $stable(phase)); // R6

endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int ENT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_ent,
  input  phase_e            wr_phase,
  input  logic [COMP_W-1:0] wr_byte,
  input  logic [IDX_W-1:0]  rd_idx,
  input  phase_e            rd_phase,
  output logic [COMP_W-1:0] rd_byte,
  input  logic [IDX_W-1:0]  pix_index,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic [RGB_W-1:0]  cur_mask_rgb,
  output logic [RGB_W-1:0]  cur_bit_rgb
);
  localparam int unsigned N_PAL = 1 << IDX_W;
  localparam int unsigned N_ENT = N_PAL + N_OVL;

  logic [RGB_W-1:0] ent_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_ent == ENT_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q[e] <= reset_colour(e, N_PAL);
      else if (sel)
        ent_q[e][comp_lsb(wr_phase) +: COMP_W] <= wr_byte;
    end
  end

  logic [RGB_W-1:0] rd_rgb;
  assign rd_rgb  = ent_q[rd_idx];
  assign rd_byte = rd_rgb[comp_lsb(rd_phase) +: COMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= ent_q[pix_index];
  end

  assign cur_mask_rgb = ent_q[N_PAL + 2];
  assign cur_bit_rgb  = ent_q[N_PAL + 3];

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_ent < ENT_W'(N_ENT))); // R2
  AST_CURSOR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_ent == ENT_W'(N_PAL + 2)) |=> $stable(cur_mask_rgb)); // R7

endmodule

// File: rtl/clut_dac_port.sv
module clut_dac_port
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [IDX_W-1:0]  pix_index,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic [RGB_W-1:0]  cur_mask_rgb,
  output logic [RGB_W-1:0]  cur_bit_rgb
);
  localparam int ENT_W = $clog2((1 << IDX_W) + N_OVL);

  logic [IDX_W-1:0]  idx;
  phase_e            phase;
  logic              wr_comp, rd_comp;
  logic [ENT_W-1:0]  wr_ent;
  logic [COMP_W-1:0] wr_byte, rd_byte;

  clut_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ENT_W(ENT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .idx(idx), .phase(phase),
    .wr_comp(wr_comp), .rd_comp(rd_comp), .wr_ent(wr_ent), .wr_byte(wr_byte)
  );

  clut_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_comp), .wr_ent(wr_ent),
    .wr_phase(phase), .wr_byte(wr_byte), .rd_idx(idx), .rd_phase(phase),
    .rd_byte(rd_byte), .pix_index(pix_index), .pix_rgb(pix_rgb),
    .cur_mask_rgb(cur_mask_rgb), .cur_bit_rgb(cur_bit_rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reg_rdata <= '0;
    else if (rd_comp) reg_rdata <= {rd_byte, {(DATA_W-COMP_W){1'b0}}};
  end

  AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-COMP_W-1:0] == '0); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_comp |=> $stable(reg_rdata)); // R4

endmodule

// File: tb/clut_dac_port_tb.sv
module clut_dac_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pix_index = '0;
  logic [23:0] pix_rgb, cur_mask_rgb, cur_bit_rgb;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  logic [23:0] m_ent [260];
  logic [7:0]  m_idx;
  int          m_ph;

  always #2 clk = ~clk;

  clut_dac_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_index(pix_index), .pix_rgb(pix_rgb),
    .cur_mask_rgb(cur_mask_rgb), .cur_bit_rgb(cur_bit_rgb)
  );

  function automatic logic [7:0] get_comp(input logic [23:0] c, input int ph);
    return (ph == 0) ? c[23:16] : (ph == 1) ? c[15:8] : c[7:0];
  endfunction

  function automatic logic [23:0] put_comp(input logic [23:0] c, input int ph,
                                           input logic [7:0] b);
    logic [23:0] r = c;
    if (ph == 0) r[23:16] = b; else if (ph == 1) r[15:8] = b; else r[7:0] = b;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int e = 0; e < 260; e++)
      m_ent[e] = (e == 255 || e == 256 || e == 258) ? 24'hFFFFFF : 24'h0;
    m_idx = 0;
    m_ph  = 0;
  endtask

  task automatic advance();
    if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
    else m_ph++;
  endtask

  // One bus cycle; inputs driven away from the edge, outputs checked 1 ns after it.
  task automatic op(input bit wr, input bit rd, input logic [3:0] a,
                    input logic [31:0] d, input logic [7:0] pi, input string tag);
    logic [23:0] exp_pix;
    logic [31:0] exp_rd;
    bit          do_rd;
    int          tgt;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; pix_index = pi;
    exp_pix = m_ent[pi];
    do_rd   = rd && !wr;
    exp_rd  = {get_comp(m_ent[m_idx], m_ph), 24'h0};
    if (wr) begin
      if (a == 4'd0) begin m_idx = d[31:24]; m_ph = 0; end
      else if (a == 4'd4 || a == 4'd12) begin
        tgt = (a == 4'd12) ? 256 + int'(m_idx[1:0]) : int'(m_idx);
        m_ent[tgt] = put_comp(m_ent[tgt], m_ph, d[31:24]);
        advance();
      end
    end else if (rd) advance();
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk({tag, " R8 lookup"}, {8'h0, pix_rgb}, {8'h0, exp_pix});
    chk("R7 cursor mask colour", {8'h0, cur_mask_rgb}, {8'h0, m_ent[258]});
    chk("R7 cursor bit colour", {8'h0, cur_bit_rgb}, {8'h0, m_ent[259]});
    if (do_rd) chk({tag, " R4 read data"}, reg_rdata, exp_rd);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R5: reset colours seen through the lookup port and cursor outputs
    for (int p = 0; p < 256; p++) op(0, 0, 4'd0, 0, 8'(p), "R5 reset colour");
    chk("R5 cursor mask white", {8'h0, cur_mask_rgb}, 32'h00FFFFFF);
    chk("R5 cursor bit black", {8'h0, cur_bit_rgb}, 32'h0);
    op(0, 1, 4'd0, 0, 8'd0, "R5 index/phase zero");
    // R1: index load mid-sequence resets phase
    op(1, 0, 4'd0, 32'h1000_0000, 8'd0, "R1");
    op(1, 0, 4'd4, 32'hAA00_0000, 8'd0, "R2");
    op(1, 0, 4'd0, 32'h1100_0000, 8'd0, "R1");
    op(1, 0, 4'd4, 32'h5500_0000, 8'd0, "R1");
    op(0, 0, 4'd0, 0, 8'h11, "R1 phase red after load");
    chk("R1 entry 0x11 red", {8'h0, pix_rgb}, 32'h00550000);
    // R3: wrap at 255
    op(1, 0, 4'd0, 32'hFF00_0000, 8'd0, "R3");
    op(1, 0, 4'd4, 32'h0100_0000, 8'd0, "R3");
    op(1, 0, 4'd4, 32'h0200_0000, 8'd0, "R3");
    op(1, 0, 4'd4, 32'h0300_0000, 8'd0, "R3");
    op(1, 0, 4'd4, 32'h0400_0000, 8'd0, "R3 wrap to 0");
    op(0, 0, 4'd0, 0, 8'd0, "R3 entry 0 red");
    chk("R3 wrapped index hits entry 0", {8'h0, pix_rgb[23:16]}, 32'h04);
    // R2/R7: overlay alias, index 0x7E -> overlay 2
    op(1, 0, 4'd0, 32'h7E00_0000, 8'd0, "R2");
    op(1, 0, 4'd12, 32'h1200_0000, 8'd0, "R2 overlay");
    op(1, 0, 4'd12, 32'h3400_0000, 8'd0, "R2 overlay");
    op(1, 0, 4'd12, 32'h5600_0000, 8'd0, "R2 overlay");
    chk("R7 overlay2 via alias", {8'h0, cur_mask_rgb}, 32'h00123456);
    // R6: ignored offset 8 does not disturb phase
    op(1, 0, 4'd0, 32'h2000_0000, 8'd0, "R6");
    op(1, 0, 4'd4, 32'h0A00_0000, 8'd0, "R6");
    op(1, 0, 4'd8, 32'hEE00_0000, 8'd0, "R6 ignored");
    op(1, 0, 4'd4, 32'h0B00_0000, 8'h20, "R6");
    op(0, 0, 4'd0, 0, 8'h20, "R6 green after ignored write");
    chk("R6 entry 0x20", {8'h0, pix_rgb}, 32'h000A0B00);
    // R9: same-cycle write and lookup of entry 0x30
    op(1, 0, 4'd0, 32'h3000_0000, 8'd0, "R9");
    op(1, 0, 4'd4, 32'h7700_0000, 8'h30, "R9 old value on collision");
    op(0, 0, 4'd0, 0, 8'h30, "R9 new value next cycle");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      d = $urandom;
      k = $urandom_range(0, 99);
      if (k < 5)       op(1, 0, 4'd0, d, 8'($urandom), "R1 rand");
      else if (k < 40) op(1, 0, 4'd4, d, 8'($urandom), "R2 rand");
      else if (k < 50) op(1, 0, 4'd12, d, 8'($urandom), "R2 rand overlay");
      else if (k < 58) op(1, 0, 4'($urandom), d, 8'($urandom), "R6 rand offset");
      else if (k < 62) op(1, 1, 4'd4, d, 8'($urandom), "R4 rd+wr");
      else if (k < 90) op(0, 1, 4'($urandom), 0, 8'($urandom), "R4 rand read");
      else             op(0, 0, 4'd0, 0, 8'($urandom), "R8 rand idle");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule